// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit virtual address into a 24-bit physical address. The upper six virtual bits pick a page, and the block register picks one of 64 per-process tables. Together they index an on-chip table of 4096 entries. Each entry holds a 14-bit physical page number, a present bit and a writable bit. The low ten virtual bits pass straight through as the offset within a 1 KB page.

When translation is switched off, the virtual address is zero-extended and no checks apply. When it is on, an access to a non-present page raises the absent fault, and a write to a read-only page raises the read-only fault. Either fault holds back the outgoing memory strobe. A strobe that passes is steered to one of three physical regions: ROM, RAM or devices.

Entries are loaded through a table write strobe. The entry index comes from the current block register and the page field of the current virtual address. Reset marks every entry as not present.

Top module: `vmem_xlate`

## Requirements
- R1: After reset every table entry reads as not present, so a paged read or write to any page raises `fault_absent`. This also holds for entries that were loaded before a later reset.
- R2: With `tbl_we` high at a rising edge, `tbl_wdata` is stored at index `{vaddr[15:10], blk_sel}`, where the page field is the upper six index bits. The entry is used by translations from the following cycle on. In `tbl_wdata`, bit 15 is present, bit 14 is writable and bits 13:0 are the physical page number.
- R3: `paddr[9:0]` always equals `vaddr[9:0]`.
- R4: With `page_en` high, `paddr[23:10]` equals bits 13:0 of the selected entry, in the same cycle as the address is applied.
- R5: With `page_en` low, `paddr` is `{8'h00, vaddr}` and no fault is raised, whatever the table holds.
- R6: With `page_en` high, a read or write that selects an entry whose present bit is 0 raises `fault_absent`.
- R7: With `page_en` high, a write that selects a present entry whose writable bit is 0 raises `fault_ro`. A read of the same page raises no fault.
- R8: While either fault is high, `mem_rd`, `mem_wr` and all three region selects are low. Without a fault, `mem_rd` follows `rd_en` and `mem_wr` follows `wr_en`.
- R9: While `mem_rd` or `mem_wr` is high, exactly one select is high. `sel_rom` is high for `paddr` 0x000000 to 0x0FFFFF, `sel_ram` for 0x100000 to 0xEFFFFF, and `sel_dev` for 0xF00000 to 0xFFFFFF. All selects are low otherwise.
- R10: Tables of different blocks are independent: the same virtual page under two block values uses two separate entries.
- R11: With neither `rd_en` nor `wr_en` high, both faults and all selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 16 | Virtual address |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| page_en | input | 1 | Translation enable |
| blk_sel | input | 6 | Block (per-process table) select |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_wdata | input | 16 | Table entry to store |
| paddr | output | 24 | Physical address |
| sel_rom | output | 1 | ROM region select |
| sel_ram | output | 1 | RAM region select |
| sel_dev | output | 1 | Device region select |
| mem_rd | output | 1 | Read strobe passed to memory |
| mem_wr | output | 1 | Write strobe passed to memory |
| fault_absent | output | 1 | Access to a non-present page |
| fault_ro | output | 1 | Write to a read-only page |

## Verification
Translation, fault detection, strobe gating and region decode are combinational, so each of these results is due in the same cycle as the inputs that cause it. The bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. A table write takes effect at the rising edge inside the write strobe. The bench therefore reads a new entry back only from the falling edge after that rising edge, and it checks reset effects once reset has been released.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W   = 16;
    localparam int PA_W   = 24;
    localparam int OFF_W  = 10;
    localparam int BLK_W  = 6;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int IDX_W  = VPN_W + BLK_W;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int ENT_W  = PPN_W + 2;

    localparam logic [PA_W-1:0] ROM_LAST  = 24'h0FFFFF;
    localparam logic [PA_W-1:0] DEV_FIRST = 24'hF00000;

    typedef struct packed {
        logic             present;
        logic             writable;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [1:0] {
        RGN_ROM = 2'd0,
        RGN_RAM = 2'd1,
        RGN_DEV = 2'd2
    } region_e;

    function automatic region_e region_of(input logic [PA_W-1:0] pa);
        if (pa <= ROM_LAST)       return RGN_ROM;
        else if (pa < DEV_FIRST)  return RGN_RAM;
        else                      return RGN_DEV;
    endfunction
endpackage

// File: rtl/xlate_ptab.sv
module xlate_ptab
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic [ENT_W-1:0] wdata,
    output pte_t             rd_entry
);
    logic [DEPTH-1:0] vld;
    logic [ENT_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (we) begin
            vld[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && we) begin
            store[idx] <= wdata;
        end
    end

    always_comb begin
        rd_entry = vld[idx] ? pte_t'(store[idx]) : pte_t'('0);
    end

    // R2: a stored entry is returned from the next cycle when the index is unchanged
    assert_wr_visible_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(rst) && idx == $past(idx)) |-> rd_entry == pte_t'($past(wdata)));

    // R1: right after reset nothing is present
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_entry.present);
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
    import xlate_pkg::*;
(
    input  pte_t entry,
    input  logic page_en,
    input  logic rd_en,
    input  logic wr_en,
    output logic fault_absent,
    output logic fault_ro,
    output logic pass_rd,
    output logic pass_wr
);
    logic any_fault;

    always_comb begin
        fault_absent = page_en && (rd_en || wr_en) && !entry.present;
        fault_ro     = page_en && wr_en && entry.present && !entry.writable;
        any_fault    = fault_absent || fault_ro;
        pass_rd      = rd_en && !any_fault;
        pass_wr      = wr_en && !any_fault;
    end
endmodule

// File: rtl/xlate_region.sv
module xlate_region
    import xlate_pkg::*;
(
    input  logic [PA_W-1:0] pa,
    input  logic            active,
    output logic            sel_rom,
    output logic            sel_ram,
    output logic            sel_dev
);
    region_e rgn;

    always_comb begin
        rgn     = region_of(pa);
        sel_rom = active && (rgn == RGN_ROM);
        sel_ram = active && (rgn == RGN_RAM);
        sel_dev = active && (rgn == RGN_DEV);
    end
endmodule

// File: rtl/vmem_xlate.sv
module vmem_xlate
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic             page_en,
    input  logic [BLK_W-1:0] blk_sel,
    input  logic             tbl_we,
    input  logic [ENT_W-1:0] tbl_wdata,
    output logic [PA_W-1:0]  paddr,
    output logic             sel_rom,
    output logic             sel_ram,
    output logic             sel_dev,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             fault_absent,
    output logic             fault_ro
);
    logic [IDX_W-1:0] idx;
    pte_t             entry;

    assign idx = {vaddr[VA_W-1:OFF_W], blk_sel};

    xlate_ptab u_ptab (
        .clk      (clk),
        .rst      (rst),
        .idx      (idx),
        .we       (tbl_we),
        .wdata    (tbl_wdata),
        .rd_entry (entry)
    );

    xlate_perm u_perm (
        .entry        (entry),
        .page_en      (page_en),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .fault_absent (fault_absent),
        .fault_ro     (fault_ro),
        .pass_rd      (mem_rd),
        .pass_wr      (mem_wr)
    );

    always_comb begin
        if (page_en) paddr = {entry.ppn, vaddr[OFF_W-1:0]};
        else         paddr = PA_W'(vaddr);
    end

    xlate_region u_region (
        .pa      (paddr),
        .active  (mem_rd || mem_wr),
        .sel_rom (sel_rom),
        .sel_ram (sel_ram),
        .sel_dev (sel_dev)
    );

    // R8: a fault blocks every strobe and select
    assert_fault_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (fault_absent || fault_ro) |-> (!mem_rd && !mem_wr && !sel_rom && !sel_ram && !sel_dev));

    // R9: an access that proceeds hits exactly one region
    assert_one_region_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> $countones({sel_rom, sel_ram, sel_dev}) == 1);

    // R5: translation off never faults
    assert_off_nofault_R5: assert property (@(posedge clk) disable iff (rst)
        !page_en |-> (!fault_absent && !fault_ro && paddr == PA_W'(vaddr)));

    // R7: read-only fault only on a write to a present page
    assert_ro_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
        fault_ro |-> (wr_en && !fault_absent));

    // R11: no request, no activity
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_en || wr_en) |-> !(fault_absent || fault_ro || sel_rom || sel_ram || sel_dev));
endmodule

// File: tb/tb_vmem_xlate.sv
module tb_vmem_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] vaddr;
    logic        rd_en, wr_en, page_en, tbl_we;
    logic [5:0]  blk_sel;
    logic [15:0] tbl_wdata;
    logic [23:0] paddr;
    logic        sel_rom, sel_ram, sel_dev, mem_rd, mem_wr, fault_absent, fault_ro;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    vmem_xlate dut (
        .clk(clk), .rst(rst), .vaddr(vaddr), .rd_en(rd_en), .wr_en(wr_en),
        .page_en(page_en), .blk_sel(blk_sel), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
        .paddr(paddr), .sel_rom(sel_rom), .sel_ram(sel_ram), .sel_dev(sel_dev),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .fault_absent(fault_absent), .fault_ro(fault_ro)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // outputs packed as {mem_rd, mem_wr, fault_absent, fault_ro, sel_rom, sel_ram, sel_dev}
    function automatic logic [31:0] flags();
        return {25'd0, mem_rd, mem_wr, fault_absent, fault_ro, sel_rom, sel_ram, sel_dev};
    endfunction

    task automatic put_entry(input logic [5:0] vpn, input logic [5:0] blk, input logic [15:0] ent);
        @(negedge clk);
        vaddr = {vpn, 10'h000}; blk_sel = blk; tbl_wdata = ent; tbl_we = 1'b1;
        rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic access(input logic [15:0] va, input logic [5:0] blk, input logic pe,
                          input logic rd, input logic wr);
        @(negedge clk);
        vaddr = va; blk_sel = blk; page_en = pe; rd_en = rd; wr_en = wr;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; tbl_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        access(16'h1234, 6'd3, 1'b1, 1'b1, 1'b0);
        chk("R1 absent after reset", flags(), 32'b0010000);
        chk("R8 no strobe on fault", {30'd0, mem_rd, sel_rom}, 32'd0);
    endtask

    task automatic t_translate();
        put_entry(6'd5, 6'd3, {2'b11, 14'h0400});
        access(16'h16AB, 6'd3, 1'b1, 1'b1, 1'b0);
        chk("R4 paged address", {8'd0, paddr}, 32'h1002AB);
        chk("R3 offset kept", {22'd0, paddr[9:0]}, 32'h2AB);
        chk("R2 entry visible, R9 ram read", flags(), 32'b1000010);
        access(16'h16AB, 6'd3, 1'b1, 1'b0, 1'b1);
        chk("R8 write passes, R9 ram", flags(), 32'b0100010);
    endtask

    task automatic t_blocks();
        access(16'h16AB, 6'd4, 1'b1, 1'b1, 1'b0);
        chk("R10 other block still absent", flags(), 32'b0010000);
        put_entry(6'd5, 6'd4, {2'b11, 14'h3C01});
        access(16'h16AB, 6'd4, 1'b1, 1'b1, 1'b0);
        chk("R10 block 4 address", {8'd0, paddr}, 32'hF006AB);
        chk("R9 device select", flags(), 32'b1000001);
        access(16'h16AB, 6'd3, 1'b1, 1'b1, 1'b0);
        chk("R10 block 3 unchanged", {8'd0, paddr}, 32'h1002AB);
    endtask

    task automatic t_readonly();
        put_entry(6'd7, 6'd3, {2'b10, 14'h0002});
        access(16'h1C10, 6'd3, 1'b1, 1'b1, 1'b0);
        chk("R7 read of ro page ok, R9 rom", flags(), 32'b1000100);
        chk("R4 ro page address", {8'd0, paddr}, 32'h000810);
        access(16'h1C10, 6'd3, 1'b1, 1'b0, 1'b1);
        chk("R7 ro write fault, R8 blocked", flags(), 32'b0001000);
    endtask

    task automatic t_absent();
        access(16'h2400, 6'd3, 1'b1, 1'b0, 1'b1);
        chk("R6 write to unloaded page", flags(), 32'b0010000);
        put_entry(6'd10, 6'd3, {2'b01, 14'h0123});
        access(16'h2805, 6'd3, 1'b1, 1'b1, 1'b0);
        chk("R6 present bit clear", flags(), 32'b0010000);
        access(16'h2805, 6'd3, 1'b1, 1'b0, 1'b1);
        chk("R6 not ro fault when absent", flags(), 32'b0010000);
    endtask

    task automatic t_off();
        access(16'hFFFF, 6'd3, 1'b0, 1'b0, 1'b1);
        chk("R5 zero extend", {8'd0, paddr}, 32'h00FFFF);
        chk("R5 no fault, rom", flags(), 32'b0100100);
        access(16'h1C10, 6'd3, 1'b0, 1'b0, 1'b1);
        chk("R5 ro entry ignored", flags(), 32'b0100100);
        access(16'h2400, 6'd3, 1'b0, 1'b1, 1'b0);
        chk("R5 absent entry ignored", flags(), 32'b1000100);
    endtask

    task automatic t_idle();
        access(16'h2400, 6'd3, 1'b1, 1'b0, 1'b0);
        chk("R11 idle quiet", flags(), 32'd0);
        access(16'h16AB, 6'd3, 1'b1, 1'b0, 1'b0);
        chk("R11 idle present page", flags(), 32'd0);
    endtask

    task automatic t_edges();
        put_entry(6'd1, 6'd0, {2'b11, 14'h03FF});
        access(16'h07FF, 6'd0, 1'b1, 1'b1, 1'b0);
        chk("R9 rom top", {1'b0, paddr, flags()[6:0]}, {1'b0, 24'h0FFFFF, 7'b1000100});
        put_entry(6'd2, 6'd0, {2'b11, 14'h0400});
        access(16'h0800, 6'd0, 1'b1, 1'b1, 1'b0);
        chk("R9 ram bottom", {1'b0, paddr, flags()[6:0]}, {1'b0, 24'h100000, 7'b1000010});
        put_entry(6'd3, 6'd0, {2'b11, 14'h3BFF});
        access(16'h0FFF, 6'd0, 1'b1, 1'b1, 1'b0);
        chk("R9 ram top", {1'b0, paddr, flags()[6:0]}, {1'b0, 24'hEFFFFF, 7'b1000010});
        put_entry(6'd4, 6'd0, {2'b11, 14'h3C00});
        access(16'h1000, 6'd0, 1'b1, 1'b1, 1'b0);
        chk("R9 dev bottom", {1'b0, paddr, flags()[6:0]}, {1'b0, 24'hF00000, 7'b1000001});
    endtask

    task automatic t_rereset();
        do_reset();
        access(16'h16AB, 6'd3, 1'b1, 1'b1, 1'b0);
        chk("R1 reset clears loaded entry", flags(), 32'b0010000);
    endtask

    initial begin
        rst = 1'b1; vaddr = '0; rd_en = 0; wr_en = 0; page_en = 0;
        blk_sel = '0; tbl_we = 0; tbl_wdata = '0;
        do_reset();
        t_reset_state();
        t_translate();
        t_blocks();
        t_readonly();
        t_absent();
        t_off();
        t_idle();
        t_edges();
        t_rereset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule